// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the tag and state half of a set-associative cache. It holds no data. Each way of each set stores three things: a line address, a three-bit access permission and a lock owner context. A cache controller sends it one line-aligned request at a time and gets back a single registered response. Each request is one of the following:

- a lookup tagged with a request kind;
- an availability query;
- an allocation or a release;
- a permission write;
- a replacement-victim probe;
- one of three lock operations.

A tag match counts only when the stored permission is not "absent". Access is then granted according to the permission and the request kind. Replacement is true least-recently-used, kept as per-set age counters. An allocation fills the lowest-numbered free way. A request that would be illegal sets an error flag and changes no state.

Top module: `tdir_top`

## Requirements
- R1: The set index is the SET_W-bit field of `req_addr` starting at bit START_BIT, where SET_W = log2(CACHE_BYTES/ASSOC/LINE_BYTES). With the defaults, the index is bits [6:4]. Two addresses with the same index but different upper bits never match each other. An address in a different set never sees another set's lines.
- R2: After reset every way is absent (permission 0) and every lock owner is all ones. `req_ready` is 0 during reset and 1 from the first clock edge after reset is released. The LRU order after reset makes way ASSOC-1 the victim.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high in exactly the cycle after an accepted request.
  - Opcodes: 0 lookup, 1 availability, 2 allocate, 3 release, 4 permission write, 5 probe, 6 lock set, 7 lock clear, 8 lock test.
  - Opcodes 9 to 15 set `rsp_err` and change no state.
- R4: `rsp_hit` is 1 when a way of the set holds the request's line address with a permission other than absent. `rsp_way` then gives that way and `rsp_perm` gives its permission. On a miss both are 0.
  - Permission codes: absent=0, invalid=1, read-only=2, read-write=3, busy=4.
- R5: `rsp_grant` is 1 only for a lookup that hits. Request kinds are load=0, fetch=1 and store=2.
  - Read-write grants every kind.
  - Read-only grants load and fetch.
  - Every other permission denies.
- R6: `rsp_avail` is 1 when the line is present in its set or when any way of that set is absent.
- R7: Allocate is refused with `rsp_err` when the line is already present or when no way is free. Otherwise it writes the line address into the lowest-numbered absent way and reports that way in `rsp_way`. The way's permission becomes invalid (1) and its lock owner becomes all ones.
- R8: Release of a present line makes its way absent and reports the way. Release of a missing line sets `rsp_err`.
- R9: The following make a way the most recently used:
  - a lookup that hits, whatever the permission;
  - an allocation made with `req_touch` = 1.

  Allocation with `req_touch` = 0, probes, permission writes, lock operations and releases leave the order unchanged. The victim is the least recently used way.
- R10: A probe returns the victim way in `rsp_way` and its line address, with offset bits zero, in `rsp_victim`. `rsp_err` is set when the set still has an available way.
- R11: Lock operations need a present line and otherwise set `rsp_err`.
  - Lock set stores `req_ctx` as the owner.
  - Lock clear restores all ones.
  - Lock test sets `rsp_locked` when the stored owner equals `req_ctx`.
- R12: A permission write on a present line stores `req_perm`. On a miss, or with a code above 4, it sets `rsp_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned byte address |
| req_kind | input | 2 | Lookup kind: load, fetch, store |
| req_perm | input | 3 | Permission for a permission write |
| req_ctx | input | CTX_W | Lock context |
| req_touch | input | 1 | Allocation updates recency |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line present |
| rsp_way | output | WAY_W | Hit, filled or victim way |
| rsp_perm | output | 3 | Permission of the hit line |
| rsp_grant | output | 1 | Lookup access granted |
| rsp_avail | output | 1 | Line present or a way free |
| rsp_err | output | 1 | Request refused, nothing changed |
| rsp_locked | output | 1 | Lock test matched |
| rsp_victim | output | ADDR_W | Victim line address on a probe |

## Verification
The bench covers the grant rules on a line that matches but is not usable: invalid, busy, and read-only under a store. A design that granted on the tag alone would report grant there.

It also covers allocation without touch followed by a probe. A design that touched anyway would name the wrong victim.

Release is checked by re-filling the freed middle way. A design that searched for free ways from the top, or that never returned released ways, would fill the wrong way or refuse.

Finally, the bench covers a sequence of hits on an invalid line and a read-write line, followed by probes. A design whose age update ignored the touched way's own age would give duplicate ages and a wrong or missing victim.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
   typedef enum logic [3:0] {
      OP_LOOKUP  = 4'd0,
      OP_AVAIL   = 4'd1,
      OP_ALLOC   = 4'd2,
      OP_RELEASE = 4'd3,
      OP_SETPERM = 4'd4,
      OP_PROBE   = 4'd5,
      OP_LKSET   = 4'd6,
      OP_LKCLR   = 4'd7,
      OP_LKTEST  = 4'd8
   } op_e;

   typedef enum logic [2:0] {
      PM_ABSENT  = 3'd0,
      PM_INVALID = 3'd1,
      PM_RDONLY  = 3'd2,
      PM_RDWR    = 3'd3,
      PM_BUSY    = 3'd4
   } perm_e;

   typedef enum logic [1:0] {
      RK_LOAD  = 2'd0,
      RK_FETCH = 2'd1,
      RK_STORE = 2'd2
   } kind_e;

   localparam int PERM_W = 3;
endpackage

// File: rtl/tdir_grant.sv
module tdir_grant
   import tdir_pkg::*;
(
   input  logic              hit,
   input  logic [PERM_W-1:0] perm,
   input  logic [1:0]        kind,
   output logic              grant
);
   always_comb begin
      grant = 1'b0;
      if (hit) begin
         case (perm)
            PM_RDWR:   grant = 1'b1;
            PM_RDONLY: grant = (kind == RK_LOAD) || (kind == RK_FETCH);
            default:   grant = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/tdir_match.sv
module tdir_match
   import tdir_pkg::*;
#(
   parameter int ASSOC = 4,
   parameter int LA_W  = 12,
   parameter int WAY_W = 2
) (
   input  logic [LA_W-1:0]   req_line,
   input  logic [LA_W-1:0]   way_line [ASSOC],
   input  logic [PERM_W-1:0] way_perm [ASSOC],
   output logic              hit,
   output logic [WAY_W-1:0]  hit_way,
   output logic              free_any,
   output logic [WAY_W-1:0]  free_way
);
   logic [ASSOC-1:0] match_v;
   logic [ASSOC-1:0] empty_v;

   for (genvar w = 0; w < ASSOC; w++) begin : g_way
      assign empty_v[w] = (way_perm[w] == PM_ABSENT);
      assign match_v[w] = !empty_v[w] && (way_line[w] == req_line);
   end

   assign hit      = |match_v;
   assign free_any = |empty_v;

   // lowest-numbered way wins in both encoders
   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = ASSOC - 1; w >= 0; w--) begin
         if (match_v[w]) hit_way  = WAY_W'(w);
         if (empty_v[w]) free_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/tdir_lru.sv
module tdir_lru #(
   parameter int SETS  = 8,
   parameter int ASSOC = 4,
   parameter int SET_W = 3,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] set_idx,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim_way
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(ASSOC - 1);

   // age 0 = most recent, ASSOC-1 = victim; ages in a set form a permutation
   logic [WAY_W-1:0] age_q [SETS][ASSOC];
   logic [WAY_W-1:0] ref_age;

   assign ref_age = age_q[set_idx][touch_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < ASSOC; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < ASSOC; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[set_idx][w] <= '0;
            else if (age_q[set_idx][w] < ref_age)
               age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_way = '0;
      for (int w = 0; w < ASSOC; w++)
         if (age_q[set_idx][w] == OLDEST) victim_way = WAY_W'(w);
   end
endmodule

// File: rtl/tdir_top.sv
module tdir_top
   import tdir_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int LINE_BYTES  = 16,
   parameter int CACHE_BYTES = 512,
   parameter int ASSOC       = 4,
   parameter int START_BIT   = 4,
   parameter int CTX_W       = 4,
   localparam int WAY_W      = $clog2(ASSOC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   input  logic [2:0]        req_perm,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic              req_touch,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [2:0]        rsp_perm,
   output logic              rsp_grant,
   output logic              rsp_avail,
   output logic              rsp_err,
   output logic              rsp_locked,
   output logic [ADDR_W-1:0] rsp_victim
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int SETS  = CACHE_BYTES / ASSOC / LINE_BYTES;
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int LA_W  = ADDR_W - OFF_W;
   localparam logic [CTX_W-1:0] NO_OWNER = {CTX_W{1'b1}};

   // elaboration-time parameter checks
   if (SETS < 2) begin : g_err_sets
      $error("tdir_top: geometry must give at least two sets");
   end
   if ((1 << SET_W) != SETS) begin : g_err_pow2
      $error("tdir_top: set count must be a power of two");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_err_line
      $error("tdir_top: line size must be a power of two");
   end
   if (ASSOC < 2) begin : g_err_assoc
      $error("tdir_top: associativity must be at least two");
   end
   if (START_BIT < OFF_W || START_BIT + SET_W > ADDR_W) begin : g_err_start
      $error("tdir_top: index field must lie between offset and top bit");
   end

   // ------------------------------------------------------------ storage
   logic [LA_W-1:0]   line_q [SETS][ASSOC];
   logic [PERM_W-1:0] perm_q [SETS][ASSOC];
   logic [CTX_W-1:0]  ctx_q  [SETS][ASSOC];
   logic              ready_q;

   // ------------------------------------------------------------ decode
   op_e               op;
   logic              acc;
   logic [SET_W-1:0]  set_idx;
   logic [LA_W-1:0]   req_line;
   logic              unused_offset;

   assign op            = op_e'(req_op);
   assign acc           = req_valid && ready_q;
   assign set_idx       = req_addr[START_BIT +: SET_W];
   assign req_line      = req_addr[ADDR_W-1:OFF_W];
   assign unused_offset = ^req_addr[OFF_W-1:0];
   assign req_ready     = ready_q;

   logic [LA_W-1:0]   sel_line [ASSOC];
   logic [PERM_W-1:0] sel_perm [ASSOC];
   logic [CTX_W-1:0]  sel_ctx  [ASSOC];

   always_comb begin
      for (int w = 0; w < ASSOC; w++) begin
         sel_line[w] = line_q[set_idx][w];
         sel_perm[w] = perm_q[set_idx][w];
         sel_ctx[w]  = ctx_q[set_idx][w];
      end
   end

   logic             hit, free_any, grant_raw, avail;
   logic [WAY_W-1:0] hit_way, free_way, vic_way;
   logic [PERM_W-1:0] hit_perm;
   logic [CTX_W-1:0] hit_ctx;

   tdir_match #(.ASSOC(ASSOC), .LA_W(LA_W), .WAY_W(WAY_W)) u_match (
      .req_line (req_line),
      .way_line (sel_line),
      .way_perm (sel_perm),
      .hit      (hit),
      .hit_way  (hit_way),
      .free_any (free_any),
      .free_way (free_way)
   );

   assign hit_perm = hit ? sel_perm[hit_way] : PM_ABSENT;
   assign hit_ctx  = sel_ctx[hit_way];
   assign avail    = hit || free_any;

   tdir_grant u_grant (
      .hit   (hit),
      .perm  (hit_perm),
      .kind  (req_kind),
      .grant (grant_raw)
   );

   // ------------------------------------------------------------ legality
   logic err, do_alloc, do_free, do_perm, do_lkset, do_lkclr, touch_en;

   always_comb begin
      err      = 1'b0;
      do_alloc = 1'b0;
      do_free  = 1'b0;
      do_perm  = 1'b0;
      do_lkset = 1'b0;
      do_lkclr = 1'b0;
      case (op)
         OP_LOOKUP, OP_AVAIL: err = 1'b0;
         OP_ALLOC: begin
            err      = hit || !free_any;
            do_alloc = !err;
         end
         OP_RELEASE: begin
            err     = !hit;
            do_free = hit;
         end
         OP_SETPERM: begin
            err     = !hit || (req_perm > PM_BUSY);
            do_perm = !err;
         end
         OP_PROBE:  err = avail;
         OP_LKSET: begin
            err      = !hit;
            do_lkset = hit;
         end
         OP_LKCLR: begin
            err      = !hit;
            do_lkclr = hit;
         end
         OP_LKTEST: err = !hit;
         default:   err = 1'b1;
      endcase
   end

   assign touch_en = acc && (((op == OP_LOOKUP) && hit) || (do_alloc && req_touch));

   tdir_lru #(.SETS(SETS), .ASSOC(ASSOC), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .set_idx    (set_idx),
      .touch_way  ((op == OP_LOOKUP) ? hit_way : free_way),
      .victim_way (vic_way)
   );

   // ------------------------------------------------------------ state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < ASSOC; w++) begin
               line_q[s][w] <= '0;
               perm_q[s][w] <= PM_ABSENT;
               ctx_q[s][w]  <= NO_OWNER;
            end
         end
      end else begin
         ready_q <= 1'b1;
         if (acc) begin
            if (do_alloc) begin
               line_q[set_idx][free_way] <= req_line;
               perm_q[set_idx][free_way] <= PM_INVALID;
               ctx_q[set_idx][free_way]  <= NO_OWNER;
            end
            if (do_free) begin
               line_q[set_idx][hit_way] <= '0;
               perm_q[set_idx][hit_way] <= PM_ABSENT;
               ctx_q[set_idx][hit_way]  <= NO_OWNER;
            end
            if (do_perm)  perm_q[set_idx][hit_way] <= req_perm;
            if (do_lkset) ctx_q[set_idx][hit_way]  <= req_ctx;
            if (do_lkclr) ctx_q[set_idx][hit_way]  <= NO_OWNER;
         end
      end
   end

   // ------------------------------------------------------------ response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_way    <= '0;
         rsp_perm   <= PM_ABSENT;
         rsp_grant  <= 1'b0;
         rsp_avail  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_locked <= 1'b0;
         rsp_victim <= '0;
      end else begin
         rsp_valid <= acc;
         if (acc) begin
            rsp_hit    <= hit;
            rsp_perm   <= hit_perm;
            rsp_grant  <= (op == OP_LOOKUP) && grant_raw;
            rsp_avail  <= avail;
            rsp_err    <= err;
            rsp_locked <= (op == OP_LKTEST) && hit && (hit_ctx == req_ctx);
            if (op == OP_PROBE) begin
               rsp_way    <= vic_way;
               rsp_victim <= {sel_line[vic_way], {OFF_W{1'b0}}};
            end else begin
               rsp_way    <= (op == OP_ALLOC && !hit) ? free_way : hit_way;
               rsp_victim <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/tdir_chk.sv
module tdir_chk #(
   parameter int ADDR_W = 16,
   parameter int WAY_W  = 2,
   parameter int CTX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [3:0]        req_op,
   input logic [1:0]        req_kind,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [2:0]        rsp_perm,
   input logic              rsp_grant,
   input logic              rsp_avail,
   input logic              rsp_err,
   input logic              rsp_locked,
   input logic [ADDR_W-1:0] rsp_victim,
   input logic [CTX_W-1:0]  req_ctx
);
   logic acc;
   assign acc = req_valid && req_ready;

   AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> req_ready);                                           // R2
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);                                                    // R3
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid);                                                  // R3
   AST_HIT_NOT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_perm != 3'd0));                        // R4
   AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_grant) |-> rsp_hit);                                 // R5
   AST_STORE_NEEDS_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 4'd0 && req_kind == 2'd2) |=> (!rsp_grant || rsp_perm == 3'd3)); // R5
   AST_GRANT_ONLY_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op != 4'd0) |=> !rsp_grant);                               // R5
   AST_AVAIL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> rsp_avail);                                 // R6
   AST_ALLOC_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 4'd2) |=> (rsp_err == (rsp_hit || !rsp_avail)));     // R7
   AST_PROBE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 4'd5) |=> (rsp_err == rsp_avail));                   // R10
   AST_LOCK_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op != 4'd8) |=> !rsp_locked);                              // R11
   AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_locked) |-> rsp_hit);                                // R11

   logic unused_chk;
   assign unused_chk = ^{rsp_way, rsp_victim, req_ctx};
endmodule

bind tdir_top tdir_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W), .CTX_W(CTX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_op     (req_op),
   .req_kind   (req_kind),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_way    (rsp_way),
   .rsp_perm   (rsp_perm),
   .rsp_grant  (rsp_grant),
   .rsp_avail  (rsp_avail),
   .rsp_err    (rsp_err),
   .rsp_locked (rsp_locked),
   .rsp_victim (rsp_victim),
   .req_ctx    (req_ctx)
);

// File: tb/tdir_top_tb_top.sv
`timescale 1ns/1ps
module tdir_top_tb_top;
   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] addr;
      logic [1:0]  kind;
      logic [2:0]  perm;
      logic [3:0]  ctx;
      logic        touch;
      logic        e_hit;
      logic [1:0]  e_way;
      logic [2:0]  e_perm;
      logic        e_grant;
      logic        e_avail;
      logic        e_err;
      logic        e_lock;
      logic [15:0] e_vic;
      logic [7:0]  rq;
   } vec_t;

   function automatic vec_t v(int op, int addr, int kind, int perm, int ctx, int touch,
                              int hit, int way, int eperm, int grant, int avail,
                              int err, int lock, int vic, int rq);
      vec_t r;
      r.op = 4'(op);         r.addr = 16'(addr);   r.kind = 2'(kind);
      r.perm = 3'(perm);     r.ctx = 4'(ctx);      r.touch = 1'(touch);
      r.e_hit = 1'(hit);     r.e_way = 2'(way);    r.e_perm = 3'(eperm);
      r.e_grant = 1'(grant); r.e_avail = 1'(avail); r.e_err = 1'(err);
      r.e_lock = 1'(lock);   r.e_vic = 16'(vic);   r.rq = 8'(rq);
      return r;
   endfunction

   // ops: 0 lookup 1 avail 2 alloc 3 release 4 setperm 5 probe 6 lkset 7 lkclr 8 lktest
   localparam int NV = 42;
   localparam vec_t VECS [NV] = '{
      v(0,'h0000,0,0,0,0, 0,0,0,0,1,0,0,'h0000, 4),  // R4 miss after reset
      v(2,'h0000,0,0,0,1, 0,0,0,0,1,0,0,'h0000, 7),  // R7 fill way0
      v(0,'h0000,0,0,0,0, 1,0,1,0,1,0,0,'h0000, 5),  // R5 invalid denies
      v(4,'h0000,0,2,0,0, 1,0,1,0,1,0,0,'h0000,12),  // R12 -> read-only
      v(0,'h0000,0,0,0,0, 1,0,2,1,1,0,0,'h0000, 5),  // R5 RO load
      v(0,'h0000,1,0,0,0, 1,0,2,1,1,0,0,'h0000, 5),  // R5 RO fetch
      v(0,'h0000,2,0,0,0, 1,0,2,0,1,0,0,'h0000, 5),  // R5 RO store denied
      v(4,'h0000,0,3,0,0, 1,0,2,0,1,0,0,'h0000,12),  // R12 -> read-write
      v(0,'h0000,2,0,0,0, 1,0,3,1,1,0,0,'h0000, 5),  // R5 RW store
      v(2,'h0000,0,0,0,1, 1,0,3,0,1,1,0,'h0000, 7),  // R7 duplicate refused
      v(0,'h0010,0,0,0,0, 0,0,0,0,1,0,0,'h0000, 1),  // R1 other set
      v(0,'h0080,0,0,0,0, 0,0,0,0,1,0,0,'h0000, 1),  // R1 same set other tag
      v(2,'h0080,0,0,0,1, 0,1,0,0,1,0,0,'h0000, 7),  // R7 way1
      v(2,'h0100,0,0,0,1, 0,2,0,0,1,0,0,'h0000, 7),  // R7 way2
      v(4,'h0100,0,4,0,0, 1,2,1,0,1,0,0,'h0000,12),  // R12 -> busy
      v(0,'h0100,0,0,0,0, 1,2,4,0,1,0,0,'h0000, 5),  // R5 busy denies
      v(2,'h0180,0,0,0,0, 0,3,0,0,1,0,0,'h0000, 9),  // R9 fill without touch
      v(1,'h0200,0,0,0,0, 0,0,0,0,0,0,0,'h0000, 6),  // R6 full set
      v(1,'h0080,0,0,0,0, 1,1,1,0,1,0,0,'h0000, 6),  // R6 present line
      v(2,'h0200,0,0,0,1, 0,0,0,0,0,1,0,'h0000, 7),  // R7 no free way
      v(5,'h0200,0,0,0,0, 0,3,0,0,0,0,0,'h0180, 9),  // R9 untouched way3 is victim
      v(3,'h0080,0,0,0,0, 1,1,1,0,1,0,0,'h0000, 8),  // R8 release way1
      v(0,'h0080,0,0,0,0, 0,0,0,0,1,0,0,'h0000, 8),  // R8 gone
      v(3,'h0080,0,0,0,0, 0,0,0,0,1,1,0,'h0000, 8),  // R8 release missing
      v(5,'h0200,0,0,0,0, 0,3,0,0,1,1,0,'h0180,10),  // R10 probe with free way
      v(2,'h0200,0,0,0,1, 0,1,0,0,1,0,0,'h0000, 7),  // R7 reuse way1
      v(8,'h0200,0,0,15,0,1,1,1,0,1,0,1,'h0000,11),  // R11 no owner after fill
      v(6,'h0200,0,0,5,0, 1,1,1,0,1,0,0,'h0000,11),  // R11 set owner 5
      v(8,'h0200,0,0,5,0, 1,1,1,0,1,0,1,'h0000,11),  // R11 owner match
      v(8,'h0200,0,0,3,0, 1,1,1,0,1,0,0,'h0000,11),  // R11 owner mismatch
      v(7,'h0200,0,0,0,0, 1,1,1,0,1,0,0,'h0000,11),  // R11 clear
      v(8,'h0200,0,0,5,0, 1,1,1,0,1,0,0,'h0000,11),  // R11 cleared
      v(8,'h0200,0,0,15,0,1,1,1,0,1,0,1,'h0000,11),  // R11 back to no owner
      v(6,'h0300,0,0,2,0, 0,0,0,0,0,1,0,'h0000,11),  // R11 lock on miss
      v(4,'h0300,0,3,0,0, 0,0,0,0,0,1,0,'h0000,12),  // R12 write on miss
      v(4,'h0200,0,5,0,0, 1,1,1,0,1,1,0,'h0000,12),  // R12 reserved code
      v(5,'h0300,0,0,0,0, 0,3,0,0,0,0,0,'h0180,10),  // R10 legal probe
      v(0,'h0180,0,0,0,0, 1,3,1,0,1,0,0,'h0000, 9),  // R9 hit touches way3
      v(5,'h0300,0,0,0,0, 0,0,0,0,0,0,0,'h0000, 9),  // R9 victim way0
      v(0,'h0000,2,0,0,0, 1,0,3,1,1,0,0,'h0000, 9),  // R9 touch way0
      v(5,'h0300,0,0,0,0, 0,2,0,0,0,0,0,'h0100, 9),  // R9 victim way2
      v(8,'h0000,0,0,15,0,1,0,3,0,1,0,1,'h0000,11)   // R11 perm writes keep owner
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_op = '0;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic [2:0]  req_perm = '0;
   logic [3:0]  req_ctx = '0;
   logic        req_touch = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_grant, rsp_avail, rsp_err, rsp_locked;
   logic [1:0]  rsp_way;
   logic [2:0]  rsp_perm;
   logic [15:0] rsp_victim;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tdir_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm),
      .req_ctx(req_ctx), .req_touch(req_touch), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_way(rsp_way), .rsp_perm(rsp_perm), .rsp_grant(rsp_grant), .rsp_avail(rsp_avail),
      .rsp_err(rsp_err), .rsp_locked(rsp_locked), .rsp_victim(rsp_victim)
   );

   task automatic chk(string what, int rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: got %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // called at a negedge; samples the response at the following negedge
   task automatic do_req(vec_t t);
      req_valid = 1'b1; req_op = t.op; req_addr = t.addr; req_kind = t.kind;
      req_perm = t.perm; req_ctx = t.ctx; req_touch = t.touch;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("rsp_valid",  3,          32'(rsp_valid),  32'd1);
      chk("rsp_hit",    int'(t.rq), 32'(rsp_hit),    32'(t.e_hit));
      chk("rsp_way",    int'(t.rq), 32'(rsp_way),    32'(t.e_way));
      chk("rsp_perm",   int'(t.rq), 32'(rsp_perm),   32'(t.e_perm));
      chk("rsp_grant",  int'(t.rq), 32'(rsp_grant),  32'(t.e_grant));
      chk("rsp_avail",  int'(t.rq), 32'(rsp_avail),  32'(t.e_avail));
      chk("rsp_err",    int'(t.rq), 32'(rsp_err),    32'(t.e_err));
      chk("rsp_locked", int'(t.rq), 32'(rsp_locked), 32'(t.e_lock));
      chk("rsp_victim", int'(t.rq), 32'(rsp_victim), 32'(t.e_vic));
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("ready in reset (R2)", 2, 32'(req_ready), 32'd0);
      chk("valid in reset (R3)", 3, 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("ready after reset (R2)", 2, 32'(req_ready), 32'd1);
   endtask

   initial begin
      @(negedge clk);
      apply_reset();
      @(negedge clk);
      chk("idle no response (R3)", 3, 32'(rsp_valid), 32'd0);

      for (int i = 0; i < NV; i++) do_req(VECS[i]);

      @(negedge clk);
      chk("idle after traffic (R3)", 3, 32'(rsp_valid), 32'd0);

      // R3: reserved opcode refused, no state change
      do_req(v(9,'h0000,0,0,0,0, 1,0,3,0,1,1,0,'h0000,3));
      do_req(v(0,'h0000,2,0,0,0, 1,0,3,1,1,0,0,'h0000,3));

      // R1: index from bits [6:4]; 0x0470 set 7, 0x0070 same set other tag
      do_req(v(2,'h0470,0,0,0,1, 0,0,0,0,1,0,0,'h0000,1));
      do_req(v(0,'h0070,0,0,0,0, 0,0,0,0,1,0,0,'h0000,1));
      do_req(v(0,'h0470,0,0,0,0, 1,0,1,0,1,0,0,'h0000,1));

      // R2: reset mid-run empties everything, victim back to last way
      apply_reset();
      do_req(v(0,'h0000,0,0,0,0, 0,0,0,0,1,0,0,'h0000,2));
      do_req(v(0,'h0470,0,0,0,0, 0,0,0,0,1,0,0,'h0000,2));
      do_req(v(5,'h0000,0,0,0,0, 0,3,0,0,1,1,0,'h0000,2));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R3 watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule